// File: doc/BRIEF.md
# PMP Configuration Lock Controller

This block stores the per-entry configuration bytes of a physical memory protection unit, together with three security-control bits: a machine-mode lockdown bit, a machine-mode whitelist bit and a rule-lock bypass bit. Software-style write requests arrive as a word index, a 32-bit data word and a valid strobe. Each word carries four configuration bytes, and the block decides byte by byte whether the new value is taken. A separate strobe writes the security-control bits. A one-cycle command clears the lock and address-mode fields of every entry at once.

Downstream logic reads the stored bytes, the effective lock state of each entry and the three control bits. One cycle after a write, a per-entry change pulse tells the address-range logic which entries now hold a different byte, so it can recompute only those ranges. The block keeps no state other than these values and has no state machine. Every storage element is a plain register with a next-value decision.

Top module: `pmp_cfg_lock_ctrl`

## Requirements
- R1: After reset, every configuration byte is 0x00, the three control bits are 0 and all change pulses are 0.
- R2: A write with word index k targets entries 4k to 4k+3, with entry 4k+j taking data bits [8j+7:8j]. Within a byte, R is bit 0, W is bit 1, X is bit 2, the address mode is bits 4:3 and the lock L is bit 7. A byte whose entry is locked keeps its old value, while the other bytes of the same word are still written.
- R3: The bypass bit is bit 2 of the control write data. While it is set, locked entries accept writes, and `entry_locked` reads 0 for every entry. Otherwise `entry_locked[i]` equals the stored L bit of entry i.
- R4: While the lockdown bit is 0, a byte value with W=1 and R=0 is ignored and the old byte is kept. While the lockdown bit is 1, such a value is accepted.
- R5: `entry_changed[i]` is 1 for exactly the single cycle that follows a write request, and only if that request changed entry i's stored byte. A write of the value already stored gives no pulse.
- R6: The lockdown bit (data bit 0) and the whitelist bit (data bit 1) are sticky. A control write ORs data into them, so neither can return to 0 before reset. The bypass bit is simply loaded.
- R7: `unlock_all` clears L and the address mode of every entry in one cycle and leaves R, W and X as they were. It raises no change pulse, and it overrides a configuration write issued in the same cycle.
- R8: A configuration write is judged against the bypass and lockdown bits held before the edge, even when a control write is issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration word write strobe |
| cfg_wr_word | input | 2 | Index of the configuration word being written |
| cfg_wr_data | input | 32 | Four configuration bytes, one per entry |
| sec_wr_valid | input | 1 | Security-control write strobe |
| sec_wr_data | input | 3 | Bit 0 lockdown, bit 1 whitelist, bit 2 bypass |
| unlock_all | input | 1 | Clears lock and address mode in all entries |
| cfg_q | output | 128 | Stored bytes; entry i at bits [8i+7:8i] |
| entry_locked | output | 16 | Effective lock state of each entry |
| entry_changed | output | 16 | One-cycle pulse per entry whose byte changed |
| sec_mml | output | 1 | Machine-mode lockdown bit |
| sec_mmwp | output | 1 | Machine-mode whitelist bit |
| sec_rlb | output | 1 | Rule-lock bypass bit |

## Verification
Several properties are checked on every cycle: a locked entry holding its byte, a reserved encoding being rejected without lockdown, the sticky bits never falling, the unlock command clearing its fields, the bypass masking every lock, and each change pulse matching a real change of the stored byte. Some behaviour can only be shown by the bench's scenarios. This covers the mapping of word lanes to entries, the rule that a locked byte spares its neighbours in the same word, the use of pre-edge control bits when a control write and a configuration write share a cycle, and unlock taking priority over a concurrent write. The bench shows these by comparing every output against a reference model after each directed and random request.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;
    localparam int unsigned CFG_W   = 8;
    localparam int unsigned BIT_R   = 0;
    localparam int unsigned BIT_W   = 1;
    localparam int unsigned BIT_X   = 2;
    localparam int unsigned AM_LO   = 3;
    localparam int unsigned AM_HI   = 4;
    localparam int unsigned BIT_L   = 7;
    localparam int unsigned SEC_W   = 3;
    localparam int unsigned SEC_MML = 0;
    localparam int unsigned SEC_WP  = 1;
    localparam int unsigned SEC_RLB = 2;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    // Mask of the fields an unlock command clears (L and address mode).
    localparam cfg_byte_t UNLOCK_MASK = cfg_byte_t'((1 << BIT_L) | (3 << AM_LO));

    function automatic logic is_write_only(input cfg_byte_t b);
        return b[BIT_W] & ~b[BIT_R];
    endfunction
endpackage

// File: rtl/pmp_seccfg_reg.sv
module pmp_seccfg_reg
    import pmp_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [SEC_W-1:0] wr_data,
    output logic             mml,
    output logic             mmwp,
    output logic             rlb
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mml  <= 1'b0;
            mmwp <= 1'b0;
            rlb  <= 1'b0;
        end else if (wr_valid) begin
            mml  <= mml  | wr_data[SEC_MML];
            mmwp <= mmwp | wr_data[SEC_WP];
            rlb  <= wr_data[SEC_RLB];
        end
    end

    assert_mml_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mml |=> mml);
    assert_mmwp_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mmwp |=> mmwp);
endmodule

// File: rtl/pmp_cfg_entry.sv
module pmp_cfg_entry
    import pmp_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  cfg_byte_t wr_byte,
    input  logic      unlock,
    input  logic      rlb,
    input  logic      mml,
    output cfg_byte_t cfg_q,
    output logic      locked,
    output logic      changed
);
    logic blocked_by_lock;
    logic blocked_by_enc;
    logic take;

    always_comb begin
        blocked_by_lock = cfg_q[BIT_L] & ~rlb;
        blocked_by_enc  = is_write_only(wr_byte) & ~mml;
        take = wr_en & ~unlock & ~blocked_by_lock & ~blocked_by_enc
             & (wr_byte != cfg_q);
        locked = cfg_q[BIT_L] & ~rlb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            changed <= 1'b0;
        end else begin
            changed <= take;
            if (unlock)
                cfg_q <= cfg_q & ~UNLOCK_MASK;
            else if (take)
                cfg_q <= wr_byte;
        end
    end

    assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock && cfg_q[BIT_L] && !rlb) |=> $stable(cfg_q));
    assert_wonly_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock && wr_byte[BIT_W] && !wr_byte[BIT_R] && !mml) |=> $stable(cfg_q));
    assert_unlock_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (!cfg_q[BIT_L] && cfg_q[AM_HI:AM_LO] == 2'b00 && !changed));
    assert_pulse_real_R5: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (cfg_q != $past(cfg_q)));
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (changed && !take) |=> !changed);
endmodule

// File: rtl/pmp_cfg_lock_ctrl.sv
module pmp_cfg_lock_ctrl
    import pmp_cfg_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES    = 16,
    parameter int unsigned BYTES_PER_WORD = 4,
    localparam int unsigned NUM_WORDS = NUM_ENTRIES / BYTES_PER_WORD,
    localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned DATA_W    = CFG_W * BYTES_PER_WORD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_valid,
    input  logic [WIDX_W-1:0]        cfg_wr_word,
    input  logic [DATA_W-1:0]        cfg_wr_data,
    input  logic                     sec_wr_valid,
    input  logic [SEC_W-1:0]         sec_wr_data,
    input  logic                     unlock_all,
    output logic [NUM_ENTRIES*CFG_W-1:0] cfg_q,
    output logic [NUM_ENTRIES-1:0]   entry_locked,
    output logic [NUM_ENTRIES-1:0]   entry_changed,
    output logic                     sec_mml,
    output logic                     sec_mmwp,
    output logic                     sec_rlb
);
    pmp_seccfg_reg u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (sec_wr_valid),
        .wr_data  (sec_wr_data),
        .mml      (sec_mml),
        .mmwp     (sec_mmwp),
        .rlb      (sec_rlb)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        localparam int unsigned WORD = i / BYTES_PER_WORD;
        localparam int unsigned LANE = i % BYTES_PER_WORD;
        logic      hit;
        cfg_byte_t q;

        assign hit = cfg_wr_valid && (cfg_wr_word == WIDX_W'(WORD));

        pmp_cfg_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .wr_byte (cfg_wr_data[LANE*CFG_W +: CFG_W]),
            .unlock  (unlock_all),
            .rlb     (sec_rlb),
            .mml     (sec_mml),
            .cfg_q   (q),
            .locked  (entry_locked[i]),
            .changed (entry_changed[i])
        );
        assign cfg_q[i*CFG_W +: CFG_W] = q;
    end

    assert_bypass_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rlb |-> (entry_locked == '0));
    assert_unlock_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_all |=> (entry_changed == '0));
endmodule

// File: tb/pmp_cfg_lock_ctrl_tb.sv
module pmp_cfg_lock_ctrl_tb_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_valid = 1'b0;
    logic [1:0]   cfg_wr_word = '0;
    logic [31:0]  cfg_wr_data = '0;
    logic         sec_wr_valid = 1'b0;
    logic [2:0]   sec_wr_data = '0;
    logic         unlock_all = 1'b0;
    logic [N*8-1:0] cfg_q;
    logic [N-1:0] entry_locked;
    logic [N-1:0] entry_changed;
    logic         sec_mml, sec_mmwp, sec_rlb;

    pmp_cfg_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_word(cfg_wr_word), .cfg_wr_data(cfg_wr_data),
        .sec_wr_valid(sec_wr_valid), .sec_wr_data(sec_wr_data), .unlock_all(unlock_all),
        .cfg_q(cfg_q), .entry_locked(entry_locked), .entry_changed(entry_changed),
        .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0]   m_cfg [N];
    logic         m_mml, m_mmwp, m_rlb;
    logic [N-1:0] m_chg;

    function automatic logic [N*8-1:0] pack_model();
        logic [N*8-1:0] p;
        for (int i = 0; i < N; i++) p[i*8 +: 8] = m_cfg[i];
        return p;
    endfunction

    function automatic logic [N-1:0] model_locked();
        logic [N-1:0] l;
        for (int i = 0; i < N; i++) l[i] = m_cfg[i][7] & ~m_rlb;
        return l;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_cfg[i] = 8'h00;
        m_mml = 0; m_mmwp = 0; m_rlb = 0; m_chg = '0;
    endtask

    task automatic model_step(input logic wv, input logic [1:0] wi, input logic [31:0] wd,
                              input logic sv, input logic [2:0] sd, input logic un);
        m_chg = '0;
        if (un) begin
            for (int i = 0; i < N; i++) m_cfg[i] = m_cfg[i] & 8'h67;
        end else if (wv) begin
            for (int j = 0; j < 4; j++) begin
                int k;
                logic [7:0] b;
                k = int'(wi) * 4 + j;
                b = wd[j*8 +: 8];
                if (!(m_cfg[k][7] && !m_rlb) && !(b[1] && !b[0] && !m_mml) && b != m_cfg[k]) begin
                    m_cfg[k] = b;
                    m_chg[k] = 1'b1;
                end
            end
        end
        if (sv) begin
            m_mml  = m_mml | sd[0];
            m_mmwp = m_mmwp | sd[1];
            m_rlb  = sd[2];
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (cfg_q !== pack_model()) begin
            miscompares++;
            $display("FAIL %s cfg_q act=%h exp=%h", tag, cfg_q, pack_model());
        end
        if (entry_locked !== model_locked()) begin
            miscompares++;
            $display("FAIL %s entry_locked act=%h exp=%h", tag, entry_locked, model_locked());
        end
        if (entry_changed !== m_chg) begin
            miscompares++;
            $display("FAIL %s entry_changed act=%h exp=%h", tag, entry_changed, m_chg);
        end
        if ({sec_rlb, sec_mmwp, sec_mml} !== {m_rlb, m_mmwp, m_mml}) begin
            miscompares++;
            $display("FAIL %s sec act=%b exp=%b", tag, {sec_rlb, sec_mmwp, sec_mml},
                     {m_rlb, m_mmwp, m_mml});
        end
    endtask

    task automatic apply(input logic wv, input logic [1:0] wi, input logic [31:0] wd,
                         input logic sv, input logic [2:0] sd, input logic un, input string tag);
        @(negedge clk);
        cfg_wr_valid = wv; cfg_wr_word = wi; cfg_wr_data = wd;
        sec_wr_valid = sv; sec_wr_data = sd; unlock_all = un;
        model_step(wv, wi, wd, sv, sd, un);
        @(negedge clk);
        cfg_wr_valid = 0; sec_wr_valid = 0; unlock_all = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        apply(0, 2'd0, 32'h0, 0, 3'b000, 0, tag);
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");

        // R2: lane mapping, entry 1 becomes locked
        apply(1, 2'd0, 32'h0000_8B03, 0, 3'b000, 0, "R2 lanes");
        idle("R5 pulse ends");
        apply(1, 2'd0, 32'h5555_5555, 0, 3'b000, 0, "R2 locked byte spared");
        apply(1, 2'd3, 32'h9F00_0001, 0, 3'b000, 0, "R2 top word");
        // R4: write-only encoding without lockdown
        apply(1, 2'd1, 32'h0202_0207, 0, 3'b000, 0, "R4 reserved dropped");
        // R5: equal write
        apply(1, 2'd1, 32'h0000_0007, 0, 3'b000, 0, "R5 equal write");
        // R8: bypass set together with a locked write uses old bypass
        apply(1, 2'd0, 32'h0000_0100, 1, 3'b100, 0, "R8 old bypass");
        // R3: with bypass, locked entry writable and unlocked
        apply(1, 2'd0, 32'h0000_0100, 0, 3'b000, 0, "R3 bypass write");
        apply(1, 2'd0, 32'h0000_8F00, 0, 3'b000, 0, "R3 relock under bypass");
        apply(0, 2'd0, 32'h0, 1, 3'b000, 0, "R3 bypass cleared");
        // R7: unlock overrides concurrent write
        apply(1, 2'd3, 32'h0101_0101, 0, 3'b000, 1, "R7 unlock all");
        // R6: set lockdown and whitelist, try to clear
        apply(1, 2'd2, 32'h0000_0002, 1, 3'b011, 0, "R8 old lockdown");
        apply(0, 2'd0, 32'h0, 1, 3'b100, 0, "R6 sticky hold");
        apply(0, 2'd0, 32'h0, 1, 3'b000, 0, "R6 bypass clears");
        apply(1, 2'd2, 32'h0000_0002, 0, 3'b000, 0, "R4 reserved accepted");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            logic        wv, sv, un;
            r  = $urandom;
            wv = r[0] | r[1];
            sv = (r[5:2] == 4'd0);
            un = (r[10:6] == 5'd0);
            if (r[15:11] == 5'd0 && !un) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                model_reset();
                compare("R1 random reset");
            end
            apply(wv, 2'($urandom), $urandom, sv, 3'({$urandom} & 32'h5), un, "R2 R4 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule